// File: doc/BRIEF.md
# Status Register and Branch Decider

This block keeps the eight status flags of a small 8-bit processor and works out the flag-related control flow of its instruction set. On every cycle that a decoded opcode is presented, together with the address of that instruction and the signed offset byte that follows it, the block computes the address of the next instruction. It applies any flag clearing the opcode asks for, and it reports how many machine cycles the instruction occupies.

Five opcodes each clear a single flag. Three opcodes branch conditionally on the negative or overflow flag, and one branches always. Every other opcode is passed over untouched and flagged as not handled, so that another execution unit can take it. Arithmetic results reach the register through a plain parallel load port.

Top module: `status_branch_unit`

## Requirements
- R1: During and after reset, before any operation, `flags` is 8'h00, `res_valid` is 0, `next_pc` is 0, `cycles` is 0 and `not_handled` is 0.
- R2: `flag_wr` high at a clock edge loads `flag_wdata` into `flags`, seen on the next cycle. A load wins over a flag clear issued in the same cycle.
- R3: `flags` bit positions are 7=N, 6=V, 5=T, 4=B, 3=D, 2=I, 1=Z, 0=C. Opcode 8'h18 clears C, 8'hD8 clears D, 8'h58 clears I, 8'h12 clears T and 8'hB8 clears V. Every other bit keeps its value.
- R4: A flag-clear opcode gives `next_pc` = `pc_in` + 1 and `cycles` = 2.
- R5: Opcode 8'h10 is taken when N is 0 and falls through when N is 1.
- R6: Opcode 8'h50 is taken when V is 0. Opcode 8'h70 is taken when V is 1. Each falls through otherwise.
- R7: Opcode 8'h80 is always taken and reports `cycles` = 4. The conditional branches report `cycles` = 2 whether taken or not. No branch changes `flags`.
- R8: A taken branch gives `next_pc` = `pc_in` + 2 + the sign-extended `rel_off`, modulo 2^PC_W. A branch that falls through gives `pc_in` + 2.
- R9: Any other opcode gives `next_pc` = `pc_in`, `cycles` = 0 and `not_handled` = 1, and leaves `flags` unchanged.
- R10: Results appear with `res_valid` = 1 one cycle after `op_valid`. With `op_valid` low, `res_valid` is 0 the next cycle and `next_pc`, `cycles` and `not_handled` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An opcode is presented this cycle |
| opcode | input | 8 | Decoded opcode byte |
| pc_in | input | PC_W | Address of the presented instruction |
| rel_off | input | 8 | Signed relative offset byte |
| flag_wr | input | 1 | Parallel load of the status register |
| flag_wdata | input | 8 | Value for the parallel load |
| res_valid | output | 1 | Results of the previous cycle's opcode are valid |
| next_pc | output | PC_W | Address of the next instruction |
| flags | output | 8 | Current status register |
| cycles | output | 3 | Machine cycles of the instruction |
| not_handled | output | 1 | Opcode is not one this block executes |

## Verification
Every result of an opcode, including its flag effect, is due exactly one clock edge after `op_valid`. A parallel load is likewise visible one edge after `flag_wr`. The driver changes inputs on falling edges and pushes one expected item per opcode into a queue. The monitor pops an item on each falling edge where `res_valid` is high, so it compares one edge after the issue with nothing in between. Load results are sampled directly on the falling edge after the load.

// File: rtl/status_branch_unit.sv
module status_branch_unit #(
  parameter int PC_W = 16,
  parameter logic [7:0] FLAG_RST = 8'h00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [7:0]      opcode,
  input  logic [PC_W-1:0] pc_in,
  input  logic [7:0]      rel_off,
  input  logic            flag_wr,
  input  logic [7:0]      flag_wdata,
  output logic            res_valid,
  output logic [PC_W-1:0] next_pc,
  output logic [7:0]      flags,
  output logic [2:0]      cycles,
  output logic            not_handled
);
  localparam int BIT_N = 7, BIT_V = 6, BIT_T = 5, BIT_D = 3, BIT_I = 2, BIT_C = 0;

  logic [7:0]      clr_mask;
  logic            is_clr, is_br, take;
  logic [2:0]      cyc;
  logic [PC_W-1:0] seq1, seq2, target, pc_n;

  assign seq1   = pc_in + PC_W'(1);
  assign seq2   = pc_in + PC_W'(2);
  assign target = seq2 + PC_W'({{(PC_W-8){rel_off[7]}}, rel_off});

  always_comb begin
    clr_mask = 8'h00;
    is_br    = 1'b0;
    take     = 1'b0;
    unique case (opcode)
      8'h18: clr_mask[BIT_C] = 1'b1;
      8'hD8: clr_mask[BIT_D] = 1'b1;
      8'h58: clr_mask[BIT_I] = 1'b1;
      8'h12: clr_mask[BIT_T] = 1'b1;
      8'hB8: clr_mask[BIT_V] = 1'b1;
      8'h10: begin is_br = 1'b1; take = ~flags[BIT_N]; end
      8'h50: begin is_br = 1'b1; take = ~flags[BIT_V]; end
      8'h70: begin is_br = 1'b1; take =  flags[BIT_V]; end
      8'h80: begin is_br = 1'b1; take = 1'b1; end
      default: ;
    endcase
  end

  assign is_clr = |clr_mask;
  assign cyc    = (opcode == 8'h80) ? 3'd4 : (is_clr || is_br) ? 3'd2 : 3'd0;
  assign pc_n   = is_clr ? seq1 : is_br ? (take ? target : seq2) : pc_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags       <= FLAG_RST;
      res_valid   <= 1'b0;
      next_pc     <= '0;
      cycles      <= '0;
      not_handled <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (flag_wr)
        flags <= flag_wdata;
      else if (op_valid && is_clr)
        flags <= flags & ~clr_mask;
      if (op_valid) begin
        next_pc     <= pc_n;
        cycles      <= cyc;
        not_handled <= ~(is_clr | is_br);
      end
    end
  end
endmodule

module status_branch_unit_chk #(parameter int PC_W = 16) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [7:0]      opcode,
  input logic [PC_W-1:0] pc_in,
  input logic [7:0]      rel_off,
  input logic            flag_wr,
  input logic [7:0]      flag_wdata,
  input logic            res_valid,
  input logic [PC_W-1:0] next_pc,
  input logic [7:0]      flags,
  input logic [2:0]      cycles,
  input logic            not_handled
);
  logic known;
  assign known = (opcode == 8'h18) || (opcode == 8'hD8) || (opcode == 8'h58) ||
                 (opcode == 8'h12) || (opcode == 8'hB8) || (opcode == 8'h10) ||
                 (opcode == 8'h50) || (opcode == 8'h70) || (opcode == 8'h80);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> flags == $past(flag_wdata));

  assert_clear_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && opcode == 8'h18) |=> (flags == ($past(flags) & 8'hFE)));

  assert_clear_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && opcode == 8'hB8) |=> (flags == ($past(flags) & 8'hBF)));

  assert_always_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 8'h80) |=>
      (cycles == 3'd4 && next_pc == $past(pc_in) + PC_W'(2) +
       PC_W'({{(PC_W-8){$past(rel_off[7])}}, $past(rel_off)})));

  assert_branch_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && (opcode == 8'h10 || opcode == 8'h50 || opcode == 8'h70 || opcode == 8'h80))
      |=> $stable(flags));

  assert_unknown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && !known) |=>
      (not_handled && cycles == 3'd0 && next_pc == $past(pc_in) && $stable(flags)));

  assert_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(next_pc) && $stable(cycles) && $stable(not_handled)));
endmodule

bind status_branch_unit status_branch_unit_chk #(.PC_W(PC_W)) chk_i (.*);

// File: tb/status_branch_unit_test.sv
module status_branch_unit_test;
  localparam int PC_W = 16;
  logic            clk = 1'b0, rst_n = 1'b0;
  logic            op_valid = 1'b0, flag_wr = 1'b0;
  logic [7:0]      opcode = 8'h00, rel_off = 8'h00, flag_wdata = 8'h00;
  logic [PC_W-1:0] pc_in = '0;
  logic            res_valid, not_handled;
  logic [PC_W-1:0] next_pc;
  logic [7:0]      flags;
  logic [2:0]      cycles;

  int tests = 0, fails = 0;
  logic [7:0] mflags = 8'h00;
  bit done = 1'b0;

  typedef struct {
    logic [PC_W-1:0] pc;
    logic [7:0]      fl;
    logic [2:0]      cy;
    logic            nh;
    string           req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  status_branch_unit #(.PC_W(PC_W)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one opcode; optionally a simultaneous load (R2 priority).
  task automatic issue(input logic [7:0] op, input logic [PC_W-1:0] pc,
                       input logic [7:0] off, input string req,
                       input bit ld = 0, input logic [7:0] ldv = 8'h00);
    exp_t e;
    logic [PC_W-1:0] sx;
    bit tk;
    sx = {{(PC_W-8){off[7]}}, off};
    e.pc = pc; e.cy = 0; e.nh = 1; e.req = req;
    case (op)
      8'h18, 8'hD8, 8'h58, 8'h12, 8'hB8: begin
        e.pc = pc + 1; e.cy = 2; e.nh = 0;
        case (op)
          8'h18: mflags[0] = 1'b0;
          8'hD8: mflags[3] = 1'b0;
          8'h58: mflags[2] = 1'b0;
          8'h12: mflags[5] = 1'b0;
          default: mflags[6] = 1'b0;
        endcase
      end
      8'h10, 8'h50, 8'h70, 8'h80: begin
        tk = (op == 8'h80) || (op == 8'h10 && !mflags[7]) ||
             (op == 8'h50 && !mflags[6]) || (op == 8'h70 && mflags[6]);
        e.pc = tk ? pc + 2 + sx : pc + 2;
        e.cy = (op == 8'h80) ? 3'd4 : 3'd2; e.nh = 0;
      end
      default: ;
    endcase
    if (ld) mflags = ldv;
    e.fl = mflags;
    @(negedge clk);
    op_valid = 1; opcode = op; pc_in = pc; rel_off = off;
    flag_wr = ld; flag_wdata = ldv;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 0; flag_wr = 0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk);
    op_valid = 0; flag_wr = 1; flag_wdata = v; mflags = v;
    @(negedge clk);
    flag_wr = 0;
    chk(flags == v, "R2", "flags after load", flags, v);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (q.size() == 0) begin
          chk(0, "R10", "unexpected res_valid", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(next_pc == e.pc, e.req, "next_pc", next_pc, e.pc);
          chk(flags == e.fl, e.req, "flags", flags, e.fl);
          chk(cycles == e.cy, e.req, "cycles", cycles, e.cy);
          chk(not_handled == e.nh, e.req, "not_handled", not_handled, e.nh);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flags == 8'h00 && !res_valid && next_pc == 0 && cycles == 0 && !not_handled,
        "R1", "reset outputs", {flags, 7'b0, res_valid, next_pc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!res_valid && flags == 8'h00, "R1", "after reset", {res_valid, flags}, 0);

    // R3/R4: clear each flag from all-ones, back to back
    load(8'hFF);
    issue(8'h18, 16'h1000, 8'h00, "R3_clc");
    issue(8'hD8, 16'h1001, 8'h00, "R3_cld");
    issue(8'h58, 16'h1002, 8'h00, "R4_cli");
    issue(8'h12, 16'h1003, 8'h00, "R3_clt");
    issue(8'hB8, 16'hFFFF, 8'h00, "R4_clv_wrap");
    idle();
    // R10: outputs hold while idle
    @(negedge clk);
    chk(!res_valid && next_pc == 16'h0000 && cycles == 2, "R10", "hold when idle",
        {res_valid, next_pc}, 0);

    // R5: branch on N clear
    load(8'h00);
    issue(8'h10, 16'h2000, 8'h10, "R5_taken");
    idle();
    load(8'h80);
    issue(8'h10, 16'h2000, 8'h10, "R5_not_taken");
    // R6: V branches
    load(8'h40);
    issue(8'h50, 16'h3000, 8'h05, "R6_bvc_nt");
    issue(8'h70, 16'h3000, 8'hFB, "R6_bvs_t");
    idle();
    load(8'hBF);
    issue(8'h50, 16'h3000, 8'hFB, "R6_bvc_t");
    issue(8'h70, 16'h3000, 8'h05, "R6_bvs_nt");
    // R7/R8: always branch, extremes and wrap
    issue(8'h80, 16'h4000, 8'h80, "R8_min");
    issue(8'h80, 16'h4000, 8'h7F, "R8_max");
    issue(8'h80, 16'hFFF0, 8'h7F, "R8_wrap_up");
    issue(8'h80, 16'h0001, 8'hF0, "R7_wrap_down");
    // R9: unhandled opcodes
    issue(8'h00, 16'h5000, 8'h12, "R9_00");
    issue(8'hEA, 16'h5123, 8'h34, "R9_ea");
    issue(8'h9E, 16'hABCD, 8'h80, "R9_9e");
    // R2: load wins over clear issued together
    issue(8'h18, 16'h6000, 8'h00, "R2_priority", 1, 8'h5B);
    idle();
    @(negedge clk);
    chk(flags == 8'h5B, "R2", "flags after priority", flags, 8'h5B);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10", "scoreboard drained", q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule